// File: doc/BRIEF.md
# Region-Configured External Bus Sequencer

This block connects a 32-bit core memory request port to an external bus with separate address and data lines. The top bits of each request address pick one of sixteen regions. Each region has its own settings: a port width of 8, 16 or 32 bits, a byte order, and a number of wait states. Software loads these settings through a small configuration write port. A single 32-bit core access becomes one, two or four narrow external bus cycles. Each bus cycle is stretched by the region's wait count. For big-endian regions the bytes are reversed on the way in and on the way out.

Narrow devices sit on the low-order lanes of the data bus. Each beat moves the next group of bytes at the next higher byte address. The core starts an access with a one-cycle `core_start` pulse. It then sees a single `core_ready` pulse once the last bus cycle has finished. Read data is valid on `core_rdata` during that pulse.

The sequencer has five states. Its transitions are:
- IDLE goes to ADDR when a start is accepted.
- ADDR goes to WAIT when the wait count is non-zero, and to DATA otherwise.
- WAIT goes to DATA when its counter expires.
- DATA goes back to ADDR for the next beat, or to DONE after the final beat.
- DONE goes to IDLE.

Top module: `rgn_xbus_ctrl`

## Requirements
- R1: After reset every region is 32-bit wide, little-endian, with 15 wait states. `xb_cyc`, `xb_ads` and `core_ready` are low while the block is idle.
- R2: The region is selected by `core_addr[31:28]`. The configuration fields are encoded as follows:
  - `cfg_width`: 2'b00 selects 8 bits, 2'b01 selects 16 bits, and 2'b10 or 2'b11 selects 32 bits.
  - `cfg_big`: 1 selects big-endian.
  - `cfg_wait`: the wait count.
- R3: An access makes 4, 2 or 1 bus beats for 8-, 16- or 32-bit regions. Beat b uses address `core_addr + b*bytes`, where bytes is the region width in bytes.
- R4: Each beat has three phases, and `xb_cyc` stays high for all of them:
  - one address cycle with `xb_ads` high;
  - W wait cycles, where W is the region wait count;
  - one data cycle.
  
  `xb_addr`, `xb_we` and `xb_wdata` do not change within a beat.
- R5: On reads, each beat takes its bytes from the low lanes of `xb_rdata` at the end of the data cycle. Beat b fills byte positions b*bytes upward of the assembled word.
- R6: In a big-endian region, the bytes of the assembled read word are reversed before `core_rdata`. The bytes of `core_wdata` are reversed before being split into beats.
- R7: On writes, `xb_we` is high during the access. Beat b drives bytes b*bytes upward of the (possibly swapped) word on the low lanes of `xb_wdata`, with the upper lanes at zero.
- R8: `core_ready` is a single-cycle pulse in the cycle right after the last data cycle. If start is sampled at edge k, ready is high in cycle beats*(W+2)+1 after k, and the bus is idle in that cycle.
- R9: A `core_start` pulse that arrives while an access is in progress has no effect.
- R10: The configuration is captured when an access is accepted. A configuration write during an access does not change that access, but does apply to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Region index being configured |
| cfg_width | input | 2 | Port width code |
| cfg_big | input | 1 | Big-endian select |
| cfg_wait | input | 4 | Wait states per bus cycle |
| core_start | input | 1 | One-cycle access request |
| core_write | input | 1 | 1 = write, 0 = read |
| core_addr | input | 32 | Byte address, word aligned |
| core_wdata | input | 32 | Write data |
| core_ready | output | 1 | Access complete pulse |
| core_rdata | output | 32 | Read data, valid with ready |
| xb_ads | output | 1 | Address strobe, first cycle of a beat |
| xb_cyc | output | 1 | Bus cycle in progress |
| xb_we | output | 1 | Bus write |
| xb_addr | output | 32 | Bus byte address |
| xb_wdata | output | 32 | Bus write data |
| xb_rdata | input | 32 | Bus read data |

## Verification
The sequencer's faults show up on the ports, and each kind shows up at a predictable time:
- **Wrong wait counter or beat index.** The distance between `xb_ads` strobes changes, or the number of strobes changes, and the ready pulse moves by at least one cycle. This is visible within the first access to the affected region.
- **Wrong lane offset or swap.** Bytes end up in the wrong positions of `core_rdata`, or of the low lanes of `xb_wdata`. This is visible on the first beat or the ready cycle of the first access to a narrow or big-endian region.
- **Captured configuration that does not hold for the whole access.** A mid-access configuration write changes the timing of the access it interrupts.

// File: rtl/rgn_xbus_pkg.sv
package rgn_xbus_pkg;

    localparam int WAIT_W = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_WAIT,
        S_DATA,
        S_DONE
    } seq_state_e;

    typedef struct packed {
        logic              big;
        logic [1:0]        wcode;
        logic [WAIT_W-1:0] waits;
    } rgn_cfg_t;

    localparam rgn_cfg_t CFG_RESET = '{big: 1'b0, wcode: 2'b10, waits: '1};

    // log2 of the port width in bytes
    function automatic logic [1:0] lsz_of(input logic [1:0] wcode);
        unique case (wcode)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/rgn_cfg_bank.sv
module rgn_cfg_bank
    import rgn_xbus_pkg::*;
#(
    parameter int N_REGION = 16,
    localparam int RIDX_W = $clog2(N_REGION)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RIDX_W-1:0] wsel,
    input  rgn_cfg_t          wcfg,
    input  logic [RIDX_W-1:0] rsel,
    output rgn_cfg_t          rcfg
);

    rgn_cfg_t regs [N_REGION];

    for (genvar g = 0; g < N_REGION; g++) begin : g_rgn
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= CFG_RESET;
            end else if (we && wsel == RIDX_W'(g)) begin
                regs[g] <= wcfg;
            end
        end
    end

    assign rcfg = regs[rsel];

endmodule

// File: rtl/rgn_lane_steer.sv
module rgn_lane_steer
    import rgn_xbus_pkg::*;
(
    input  logic [1:0]  lsz,
    input  logic        big,
    input  logic [1:0]  beat,
    input  logic [31:0] wword,
    input  logic [31:0] bus_rd,
    input  logic [31:0] acc,
    output logic [31:0] bus_wd,
    output logic [31:0] acc_next,
    output logic [31:0] rd_out,
    output logic [1:0]  byte_off
);

    logic [31:0] mask;
    logic [4:0]  shamt;
    logic [31:0] wsw;

    always_comb begin
        unique case (lsz)
            2'd0:    mask = 32'h0000_00FF;
            2'd1:    mask = 32'h0000_FFFF;
            default: mask = 32'hFFFF_FFFF;
        endcase
        byte_off = beat << lsz;
        shamt    = {byte_off, 3'b000};
        wsw      = big ? swap32(wword) : wword;
        bus_wd   = (wsw >> shamt) & mask;
        acc_next = (acc & ~(mask << shamt)) | ((bus_rd & mask) << shamt);
        rd_out   = big ? swap32(acc) : acc;
    end

endmodule

// File: rtl/rgn_beat_seq.sv
module rgn_beat_seq
    import rgn_xbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        lsz,
    input  logic [WAIT_W-1:0] waits,
    output logic              accept,
    output logic              ads,
    output logic              cyc,
    output logic              capture,
    output logic              done,
    output logic [1:0]        beat
);

    seq_state_e        state_q, state_d;
    logic [WAIT_W-1:0] wcnt_q, wcnt_d;
    logic [1:0]        beat_q, beat_d;
    logic [1:0]        last_beat;

    assign last_beat = (lsz == 2'd0) ? 2'd3 : (lsz == 2'd1) ? 2'd1 : 2'd0;

    always_comb begin
        state_d = state_q;
        wcnt_d  = wcnt_q;
        beat_d  = beat_q;
        unique case (state_q)
            S_IDLE: if (start) begin
                state_d = S_ADDR;
                beat_d  = 2'd0;
            end
            S_ADDR: begin
                wcnt_d  = waits;
                state_d = (waits == '0) ? S_DATA : S_WAIT;
            end
            S_WAIT: begin
                wcnt_d = wcnt_q - 1'b1;
                if (wcnt_q == WAIT_W'(1)) state_d = S_DATA;
            end
            S_DATA: begin
                if (beat_q == last_beat) begin
                    state_d = S_DONE;
                end else begin
                    beat_d  = beat_q + 1'b1;
                    state_d = S_ADDR;
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            wcnt_q  <= '0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            wcnt_q  <= wcnt_d;
            beat_q  <= beat_d;
        end
    end

    always_comb begin
        accept  = 1'b0;
        ads     = 1'b0;
        cyc     = 1'b0;
        capture = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            S_IDLE: accept = start;
            S_ADDR: begin ads = 1'b1; cyc = 1'b1; end
            S_WAIT: cyc = 1'b1;
            S_DATA: begin cyc = 1'b1; capture = 1'b1; end
            S_DONE: done = 1'b1;
            default: ;
        endcase
        beat = beat_q;
    end

endmodule

// File: rtl/rgn_xbus_ctrl.sv
module rgn_xbus_ctrl
    import rgn_xbus_pkg::*;
#(
    parameter int N_REGION = 16,
    parameter int ADDR_W   = 32,
    localparam int RIDX_W  = $clog2(N_REGION)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [RIDX_W-1:0] cfg_sel,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_big,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              core_start,
    input  logic              core_write,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [31:0]       core_wdata,
    output logic              core_ready,
    output logic [31:0]       core_rdata,
    output logic              xb_ads,
    output logic              xb_cyc,
    output logic              xb_we,
    output logic [ADDR_W-1:0] xb_addr,
    output logic [31:0]       xb_wdata,
    input  logic [31:0]       xb_rdata
);

    rgn_cfg_t          rd_cfg, lat_cfg;
    logic              lat_write;
    logic [ADDR_W-1:0] lat_addr;
    logic [31:0]       lat_wdata, acc, acc_next, steer_wd;
    logic              accept, capture;
    logic [1:0]        beat, byte_off, lsz;

    rgn_cfg_bank #(.N_REGION(N_REGION)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wsel  (cfg_sel),
        .wcfg  ('{big: cfg_big, wcode: cfg_width, waits: cfg_wait}),
        .rsel  (core_addr[ADDR_W-1 -: RIDX_W]),
        .rcfg  (rd_cfg)
    );

    assign lsz = lsz_of(lat_cfg.wcode);

    rgn_beat_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (core_start),
        .lsz     (lsz),
        .waits   (lat_cfg.waits),
        .accept  (accept),
        .ads     (xb_ads),
        .cyc     (xb_cyc),
        .capture (capture),
        .done    (core_ready),
        .beat    (beat)
    );

    rgn_lane_steer u_steer (
        .lsz      (lsz),
        .big      (lat_cfg.big),
        .beat     (beat),
        .wword    (lat_wdata),
        .bus_rd   (xb_rdata),
        .acc      (acc),
        .bus_wd   (steer_wd),
        .acc_next (acc_next),
        .rd_out   (core_rdata),
        .byte_off (byte_off)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_cfg   <= CFG_RESET;
            lat_write <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            acc       <= '0;
        end else if (accept) begin
            lat_cfg   <= rd_cfg;
            lat_write <= core_write;
            lat_addr  <= core_addr;
            lat_wdata <= core_wdata;
            acc       <= '0;
        end else if (capture && !lat_write) begin
            acc <= acc_next;
        end
    end

    assign xb_addr  = lat_addr + ADDR_W'(byte_off);
    assign xb_we    = xb_cyc & lat_write;
    assign xb_wdata = xb_we ? steer_wd : 32'h0;

endmodule

// File: rtl/rgn_xbus_chk.sv
module rgn_xbus_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_ready,
    input logic              xb_ads,
    input logic              xb_cyc,
    input logic              xb_we,
    input logic [ADDR_W-1:0] xb_addr,
    input logic [31:0]       xb_wdata
);

    logic [2:0] ads_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ads_cnt <= '0;
        else if (core_ready) ads_cnt <= '0;
        else if (xb_ads)     ads_cnt <= ads_cnt + 1'b1;
    end

    // R8
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_ready |=> !core_ready);

    // R8
    ready_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_ready |-> !xb_cyc);

    // R8
    fall_gives_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xb_cyc) |-> core_ready);

    // R4
    ads_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xb_ads |-> xb_cyc);

    // R4
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xb_cyc && !xb_ads) |-> ($stable(xb_addr) && $stable(xb_we) && $stable(xb_wdata)));

    // R3
    beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_ready |-> (ads_cnt == 3'd1 || ads_cnt == 3'd2 || ads_cnt == 3'd4));

endmodule

bind rgn_xbus_ctrl rgn_xbus_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_ready (core_ready),
    .xb_ads     (xb_ads),
    .xb_cyc     (xb_cyc),
    .xb_we      (xb_we),
    .xb_addr    (xb_addr),
    .xb_wdata   (xb_wdata)
);

// File: tb/rgn_xbus_ctrl_bench.sv
module rgn_xbus_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_sel;
    logic [1:0]  cfg_width;
    logic        cfg_big;
    logic [3:0]  cfg_wait;
    logic        core_start, core_write;
    logic [31:0] core_addr, core_wdata;
    logic        core_ready;
    logic [31:0] core_rdata;
    logic        xb_ads, xb_cyc, xb_we;
    logic [31:0] xb_addr, xb_wdata, xb_rdata;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rgn_xbus_ctrl u_rgn_xbus_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_width(cfg_width),
        .cfg_big(cfg_big), .cfg_wait(cfg_wait),
        .core_start(core_start), .core_write(core_write),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .core_ready(core_ready), .core_rdata(core_rdata),
        .xb_ads(xb_ads), .xb_cyc(xb_cyc), .xb_we(xb_we),
        .xb_addr(xb_addr), .xb_wdata(xb_wdata), .xb_rdata(xb_rdata)
    );

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hC3;
    endfunction

    function automatic logic [31:0] sw(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    // device model: low lane holds the byte at the bus address
    assign xb_rdata = {pat(xb_addr + 32'd3), pat(xb_addr + 32'd2),
                       pat(xb_addr + 32'd1), pat(xb_addr)};

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [3:0] idx, input logic [1:0] wc,
                           input logic big, input logic [3:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = idx; cfg_width = wc; cfg_big = big; cfg_wait = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // injected configuration for mode 2
    logic [3:0] inj_idx, inj_wait;
    logic [1:0] inj_wc;
    logic       inj_big;

    // mode 0: plain, 1: spurious start mid-access, 2: cfg write mid-access
    task automatic do_access(input logic wr, input logic [31:0] addr, input logic [31:0] wd,
                             input int lsz, input int waits, input logic big,
                             input int mode, input string tag);
        int nb = 4 >> lsz;
        int bytes = 1 << lsz;
        int cyc = 0;
        int nads = 0;
        int extra = 0;
        bit got = 0;
        logic [31:0] a_log [4];
        logic [31:0] w_log [4];
        logic        we_log [4];
        logic [31:0] rd = '0;
        logic [31:0] wsw, mask, exp;
        @(negedge clk);
        core_start = 1'b1; core_write = wr; core_addr = addr; core_wdata = wd;
        while (!got && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (xb_ads) begin
                if (nads < 4) begin
                    a_log[nads] = xb_addr; w_log[nads] = xb_wdata; we_log[nads] = xb_we;
                end
                nads++;
            end
            if (core_ready) begin got = 1; rd = core_rdata; end
            if (cyc == 1) core_start = 1'b0;
            if (mode == 1 && cyc == 2) begin core_start = 1'b1; core_addr = {4'hD, addr[27:0]}; end
            if (mode == 1 && cyc == 3) begin core_start = 1'b0; core_addr = addr; end
            if (mode == 2 && cyc == 2) begin
                cfg_we = 1'b1; cfg_sel = inj_idx; cfg_width = inj_wc;
                cfg_big = inj_big; cfg_wait = inj_wait;
            end
            if (mode == 2 && cyc == 3) cfg_we = 1'b0;
        end
        chk(got, {"R8 ready seen ", tag}, 32'(got), 32'd1);
        chk(cyc == nb * (waits + 2) + 1, {"R4 R8 latency ", tag}, 32'(cyc),
            32'(nb * (waits + 2) + 1));
        chk(nads == nb, {"R3 beat count ", tag}, 32'(nads), 32'(nb));
        wsw  = big ? sw(wd) : wd;
        mask = (bytes == 4) ? 32'hFFFF_FFFF : ((32'h1 << (bytes * 8)) - 1);
        for (int b = 0; b < nb && b < nads && b < 4; b++) begin
            chk(a_log[b] == addr + 32'(b * bytes), {"R3 beat addr ", tag},
                a_log[b], addr + 32'(b * bytes));
            if (wr) begin
                exp = (wsw >> (b * bytes * 8)) & mask;
                chk(w_log[b] == exp, {big ? "R6 R7 wdata " : "R7 wdata ", tag}, w_log[b], exp);
                chk(we_log[b] == 1'b1, {"R7 we ", tag}, 32'(we_log[b]), 32'd1);
            end
        end
        if (!wr) begin
            exp = {pat(addr + 32'd3), pat(addr + 32'd2), pat(addr + 32'd1), pat(addr)};
            if (big) exp = sw(exp);
            chk(rd == exp, {big ? "R6 rdata " : "R5 rdata ", tag}, rd, exp);
        end
        repeat (3) begin
            @(negedge clk);
            if (core_ready || xb_cyc) extra++;
        end
        chk(extra == 0, {"R8 R9 quiet after ready ", tag}, 32'(extra), 32'd0);
    endtask

    // {write, wait[3:0], big, wcode[1:0], region[3:0]}
    localparam int NV = 10;
    localparam logic [11:0] VEC [NV] = '{
        {1'b0, 4'd0, 1'b0, 2'b10, 4'd1},
        {1'b0, 4'd1, 1'b0, 2'b01, 4'd2},
        {1'b0, 4'd2, 1'b0, 2'b00, 4'd3},
        {1'b0, 4'd0, 1'b1, 2'b00, 4'd4},
        {1'b1, 4'd3, 1'b1, 2'b01, 4'd6},
        {1'b0, 4'd1, 1'b1, 2'b10, 4'd7},
        {1'b1, 4'd1, 1'b0, 2'b00, 4'd8},
        {1'b1, 4'd0, 1'b1, 2'b11, 4'd9},
        {1'b1, 4'd0, 1'b0, 2'b01, 4'd10},
        {1'b0, 4'd1, 1'b1, 2'b00, 4'd15}
    };

    initial begin
        #1_000_000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL R8 watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_width = '0; cfg_big = 1'b0;
        cfg_wait = '0; core_start = 1'b0; core_write = 1'b0; core_addr = '0; core_wdata = '0;
        inj_idx = '0; inj_wait = '0; inj_wc = '0; inj_big = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 idle outputs
        chk(!xb_cyc, "R1 xb_cyc idle", 32'(xb_cyc), 32'd0);
        chk(!xb_ads, "R1 xb_ads idle", 32'(xb_ads), 32'd0);
        chk(!core_ready, "R1 ready idle", 32'(core_ready), 32'd0);
        // R1 R2 default region config: 32-bit, little-endian, 15 waits
        do_access(1'b0, 32'h5123_4560, 32'h0, 2, 15, 1'b0, 0, "R1 default read");
        do_access(1'b1, 32'h5123_4570, 32'hA1B2_C3D4, 2, 15, 1'b0, 0, "R1 default write");

        // R2 table walk over widths, orders and waits
        for (int i = 0; i < NV; i++) begin
            logic [11:0] e;
            int l;
            e = VEC[i];
            l = (e[5:4] == 2'b00) ? 0 : (e[5:4] == 2'b01) ? 1 : 2;
            set_cfg(e[3:0], e[5:4], e[6], e[10:7]);
            do_access(e[11], {e[3:0], 20'h5A3C1, 6'(i * 5 + 3), 2'b00},
                      32'h1357_9BDF ^ (32'(i) * 32'h0101_0111), l, int'(e[10:7]), e[6],
                      0, "R2 table");
        end

        // R9 spurious start during a long access to region 12 (defaults)
        do_access(1'b0, 32'hC000_0100, 32'h0, 2, 15, 1'b0, 1, "R9 start while busy");

        // R10 cfg change mid-access affects only the next access
        set_cfg(4'd11, 2'b10, 1'b0, 4'd3);
        inj_idx = 4'd11; inj_wc = 2'b00; inj_big = 1'b1; inj_wait = 4'd0;
        do_access(1'b0, 32'hB000_0040, 32'h0, 2, 3, 1'b0, 2, "R10 current access");
        do_access(1'b0, 32'hB000_0040, 32'h0, 0, 0, 1'b1, 0, "R10 next access");

        // R6 big-endian 16-bit read and 8-bit write
        set_cfg(4'd14, 2'b01, 1'b1, 4'd2);
        do_access(1'b0, 32'hE000_0208, 32'h0, 1, 2, 1'b1, 0, "R6 be16 read");
        set_cfg(4'd14, 2'b00, 1'b1, 4'd0);
        do_access(1'b1, 32'hE000_0300, 32'hDEAD_BEEF, 0, 0, 1'b1, 0, "R6 be8 write");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule